// File: doc/BRIEF.md
# Vector FP Exception Trap Encoder

This block turns the IEEE exception flags raised by the lanes of one vector floating-point operation into either a trap or a flag update. After a start strobe it captures the per-lane flags, the lane valid bits and the 32-bit FP control word. It then walks the lanes from index 0 upward, one lane per clock. A lane traps when one of its raised flags has its enable bit set in the control word. When a lane traps, the walk stops and the block reports an 8-bit exception code, made of the lane index and a fixed-priority cause number. If no lane traps, the flags of every lane it visited are ORed together and merged into the sticky flag byte of the control word.

The element size selects the number of lanes: 32-bit gives four lanes, 64-bit gives two and 128-bit gives one. A single-element mode limits the walk to lane 0. A suppression input stops inexact from ever trapping. One done pulse presents the final code, trap bit, last visited lane and the resulting control word. These outputs then hold until the next operation ends.

Top module: `vfx_trap_encoder`

## Requirements
- R1: After reset, busy, done and trap are 0, exc_code is 0x00, last_idx is 0 and ctrl_out is 0x00000000.
- R2: elem_size 0 selects 4 lanes, 1 selects 2 lanes, and 2 or 3 selects 1 lane. An accepted start is a clock edge with start high and busy low. When k lanes are visited, done is high for the cycle that follows the k-th clock edge after the accepted start.
- R3: A lane's flag vector uses bit 4 for invalid, bit 3 for divide-by-zero, bit 2 for overflow, bit 1 for underflow and bit 0 for inexact. The enable for each flag sits at ctrl_in bits 31, 30, 29, 28 and 27 in the same order. A flag traps only when both the flag and its enable are set.
- R4: The cause numbers are invalid=1, divide-by-zero=2, overflow=3, underflow=4 and inexact=5. When several enabled flags trap in one lane, the lowest cause number wins.
- R5: When inexact_sup is 1, an inexact flag never traps, even if it is enabled.
- R6: exc_code carries the trapping lane index in bits 7:4 and the cause in bits 3:0. It is 0x00 whenever no trap occurred. The trap output equals (exc_code != 0).
- R7: Lanes are visited from index 0 upward, and the walk ends at the first trapping lane. last_idx reports the last visited lane.
- R8: With single_mode set, the walk ends after lane 0 whatever the element size.
- R9: With no trap, ctrl_out equals ctrl_in ORed with the OR of all visited lanes' flags, where the flags are placed at bits 23:19 (invalid at bit 23, inexact at bit 19). With a trap, ctrl_out equals ctrl_in unchanged.
- R10: A lane whose lane_valid bit is 0 contributes no flags and cannot trap.
- R11: A start seen while busy is ignored. The running operation completes with its own captured inputs, and no extra done follows.
- R12: done is a one-cycle pulse. trap, exc_code, last_idx and ctrl_out hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| elem_size | input | 2 | Element size: 0=32-bit, 1=64-bit, 2/3=128-bit |
| single_mode | input | 1 | Visit lane 0 only |
| inexact_sup | input | 1 | Inexact never traps |
| lane_flags | input | MAX_LANES*5 | Lane i flags at bits 5i+4:5i |
| lane_valid | input | MAX_LANES | Lane i flags are meaningful |
| ctrl_in | input | 32 | FP control word (enables 31:27, sticky flags 23:19) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Completed operation trapped |
| exc_code | output | 8 | Lane index and cause, 0 when no trap |
| last_idx | output | 4 | Last lane visited |
| ctrl_out | output | 32 | Resulting control word |

## Verification
The assertions assume that start is a clean synchronous strobe, and that elem_size, single_mode, inexact_sup, lane_flags, lane_valid and ctrl_in are sampled only at an accepted start. They therefore check results against the captured control word rather than against the live input. The stimulus drives every input at the falling edge. It changes operands only when it pulses start, except in one deliberate case: a second start with different operands is driven while the block is busy, to show that those operands are never taken.

// File: rtl/vfx_pkg.sv
package vfx_pkg;

  localparam int FLAG_W  = 5;
  localparam int CAUSE_W = 4;
  localparam int IDX_W   = 4;
  localparam int CODE_W  = IDX_W + CAUSE_W;
  localparam int CR_W    = 32;
  localparam int EN_LSB  = 27;
  localparam int STK_LSB = 19;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 4'd0,
    CAUSE_INV  = 4'd1,
    CAUSE_DZ   = 4'd2,
    CAUSE_OVF  = 4'd3,
    CAUSE_UNF  = 4'd4,
    CAUSE_INX  = 4'd5
  } cause_e;

  // Fixed-priority cause of one lane: invalid wins, inexact loses.
  function automatic cause_e pick_cause(input logic [FLAG_W-1:0] fl,
                                        input logic [FLAG_W-1:0] en,
                                        input logic              sup);
    logic [FLAG_W-1:0] hit;
    hit = fl & en;
    if (sup) hit[0] = 1'b0;
    if (hit[4])      return CAUSE_INV;
    else if (hit[3]) return CAUSE_DZ;
    else if (hit[2]) return CAUSE_OVF;
    else if (hit[1]) return CAUSE_UNF;
    else if (hit[0]) return CAUSE_INX;
    return CAUSE_NONE;
  endfunction

  // Lane count for an element size, clipped to the instantiated lanes.
  function automatic int unsigned lanes_for_size(input logic [1:0]  sz,
                                                 input int unsigned maxl);
    int unsigned n;
    case (sz)
      2'd0:    n = 4;
      2'd1:    n = 2;
      default: n = 1;
    endcase
    if (n > maxl) n = maxl;
    return n;
  endfunction

  function automatic logic [CR_W-1:0] merge_flags(input logic [CR_W-1:0]   cr,
                                                  input logic [FLAG_W-1:0] acc);
    logic [CR_W-1:0] sticky;
    sticky = '0;
    sticky[STK_LSB +: FLAG_W] = acc;
    return cr | sticky;
  endfunction

  function automatic logic [CODE_W-1:0] make_code(input logic [IDX_W-1:0] ix,
                                                  input cause_e           c);
    return (c == CAUSE_NONE) ? '0 : {ix, c};
  endfunction

endpackage

// File: rtl/vfx_capture.sv
module vfx_capture
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        launch,
  input  logic [1:0]                  elem_size,
  input  logic                        single_mode,
  input  logic                        inexact_sup,
  input  logic [MAX_LANES*FLAG_W-1:0] lane_flags,
  input  logic [MAX_LANES-1:0]        lane_valid,
  input  logic [CR_W-1:0]             ctrl_in,
  output logic [1:0]                  cap_size,
  output logic                        cap_single,
  output logic                        cap_sup,
  output logic [MAX_LANES*FLAG_W-1:0] cap_flags,
  output logic [MAX_LANES-1:0]        cap_valid,
  output logic [CR_W-1:0]             cap_ctrl
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_size   <= '0;
      cap_single <= 1'b0;
      cap_sup    <= 1'b0;
      cap_flags  <= '0;
      cap_valid  <= '0;
      cap_ctrl   <= '0;
    end else if (launch) begin
      cap_size   <= elem_size;
      cap_single <= single_mode;
      cap_sup    <= inexact_sup;
      cap_flags  <= lane_flags;
      cap_valid  <= lane_valid;
      cap_ctrl   <= ctrl_in;
    end
  end

endmodule

// File: rtl/vfx_lane_cause.sv
module vfx_lane_cause
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic [MAX_LANES*FLAG_W-1:0]          flags,
  input  logic [MAX_LANES-1:0]                 valid,
  input  logic [FLAG_W-1:0]                    enables,
  input  logic                                 sup,
  output logic [MAX_LANES-1:0][FLAG_W-1:0]     live_flags,
  output logic [MAX_LANES-1:0][CAUSE_W-1:0]    cause_v
);

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    always_comb begin
      live_flags[g] = valid[g] ? flags[g*FLAG_W +: FLAG_W] : '0;
      cause_v[g]    = pick_cause(live_flags[g], enables, sup);
    end
  end

endmodule

// File: rtl/vfx_walker.sv
module vfx_walker
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         cap_size,
  input  logic               cap_single,
  input  logic [CAUSE_W-1:0] cur_cause,
  output logic               launch,
  output logic               busy,
  output logic               stop,
  output logic [IDX_W-1:0]   idx
);

  logic [IDX_W-1:0] last_ix;
  logic             at_last;
  logic             lane_traps;

  always_comb begin
    last_ix    = IDX_W'(lanes_for_size(cap_size, MAX_LANES) - 1);
    at_last    = (idx == last_ix);
    lane_traps = (cur_cause != CAUSE_NONE);
    launch     = start && !busy;
    stop       = busy && (lane_traps || cap_single || at_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy) begin
      if (stop) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

endmodule

// File: rtl/vfx_result.sv
module vfx_result
  import vfx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic               busy,
  input  logic               stop,
  input  logic [IDX_W-1:0]   idx,
  input  logic [FLAG_W-1:0]  cur_flags,
  input  logic [CAUSE_W-1:0] cur_cause,
  input  logic [CR_W-1:0]    cap_ctrl,
  output logic               done,
  output logic               trap,
  output logic [CODE_W-1:0]  exc_code,
  output logic [IDX_W-1:0]   last_idx,
  output logic [CR_W-1:0]    ctrl_out
);

  logic [FLAG_W-1:0] acc;
  logic [FLAG_W-1:0] acc_next;
  logic              hit;

  always_comb begin
    acc_next = acc | cur_flags;
    hit      = (cur_cause != CAUSE_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      done     <= 1'b0;
      trap     <= 1'b0;
      exc_code <= '0;
      last_idx <= '0;
      ctrl_out <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        acc <= '0;
      end else if (busy) begin
        acc <= acc_next;
        if (stop) begin
          done     <= 1'b1;
          trap     <= hit;
          exc_code <= make_code(idx, cause_e'(cur_cause));
          last_idx <= idx;
          ctrl_out <= hit ? cap_ctrl : merge_flags(cap_ctrl, acc_next);
        end
      end
    end
  end

endmodule

// File: rtl/vfx_trap_encoder.sv
module vfx_trap_encoder
  import vfx_pkg::*;
#(
  parameter int MAX_LANES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  elem_size,
  input  logic                        single_mode,
  input  logic                        inexact_sup,
  input  logic [MAX_LANES*FLAG_W-1:0] lane_flags,
  input  logic [MAX_LANES-1:0]        lane_valid,
  input  logic [CR_W-1:0]             ctrl_in,
  output logic                        busy,
  output logic                        done,
  output logic                        trap,
  output logic [CODE_W-1:0]           exc_code,
  output logic [IDX_W-1:0]            last_idx,
  output logic [CR_W-1:0]             ctrl_out
);

  localparam int SEL_W = (MAX_LANES > 1) ? $clog2(MAX_LANES) : 1;

  logic [1:0]                          cap_size;
  logic                                cap_single;
  logic                                cap_sup;
  logic [MAX_LANES*FLAG_W-1:0]         cap_flags;
  logic [MAX_LANES-1:0]                cap_valid;
  logic [CR_W-1:0]                     cap_ctrl;
  logic [MAX_LANES-1:0][FLAG_W-1:0]    live_flags;
  logic [MAX_LANES-1:0][CAUSE_W-1:0]   cause_v;
  logic [IDX_W-1:0]                    idx;
  logic [SEL_W-1:0]                    sel;
  logic [FLAG_W-1:0]                   cur_flags;
  logic [CAUSE_W-1:0]                  cur_cause;
  logic                                launch_evt;
  logic                                stop_evt;

  vfx_capture #(.MAX_LANES(MAX_LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .launch(launch_evt),
    .elem_size(elem_size), .single_mode(single_mode), .inexact_sup(inexact_sup),
    .lane_flags(lane_flags), .lane_valid(lane_valid), .ctrl_in(ctrl_in),
    .cap_size(cap_size), .cap_single(cap_single), .cap_sup(cap_sup),
    .cap_flags(cap_flags), .cap_valid(cap_valid), .cap_ctrl(cap_ctrl)
  );

  vfx_lane_cause #(.MAX_LANES(MAX_LANES)) u_lanes (
    .flags(cap_flags), .valid(cap_valid),
    .enables(cap_ctrl[EN_LSB +: FLAG_W]), .sup(cap_sup),
    .live_flags(live_flags), .cause_v(cause_v)
  );

  always_comb begin
    sel       = idx[SEL_W-1:0];
    cur_flags = live_flags[sel];
    cur_cause = cause_v[sel];
  end

  vfx_walker #(.MAX_LANES(MAX_LANES)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cap_size(cap_size), .cap_single(cap_single), .cur_cause(cur_cause),
    .launch(launch_evt), .busy(busy), .stop(stop_evt), .idx(idx)
  );

  vfx_result u_res (
    .clk(clk), .rst_n(rst_n), .launch(launch_evt), .busy(busy),
    .stop(stop_evt), .idx(idx), .cur_flags(cur_flags), .cur_cause(cur_cause),
    .cap_ctrl(cap_ctrl), .done(done), .trap(trap), .exc_code(exc_code),
    .last_idx(last_idx), .ctrl_out(ctrl_out)
  );

endmodule

// File: rtl/vfx_trap_encoder_chk.sv
module vfx_trap_encoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        trap,
  input logic [7:0]  exc_code,
  input logic [3:0]  last_idx,
  input logic [31:0] ctrl_out,
  input logic [31:0] cap_ctrl,
  input logic        cap_single
);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2

  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trap) |-> (exc_code[3:0] >= 4'd1 && exc_code[3:0] <= 4'd5)); // R4

  AST_NOTRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !trap) |-> (exc_code == 8'h00)); // R6

  AST_TRAP_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && trap) |-> (ctrl_out == cap_ctrl)); // R9

  AST_SINGLE_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_single) |-> (last_idx == 4'd0)); // R8

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(cap_ctrl)); // R11

endmodule

bind vfx_trap_encoder vfx_trap_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .trap(trap), .exc_code(exc_code), .last_idx(last_idx), .ctrl_out(ctrl_out),
  .cap_ctrl(cap_ctrl), .cap_single(cap_single)
);

// File: tb/sim_vfx_trap_encoder.sv
module sim_vfx_trap_encoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  elem_size = 2'd0;
  logic        single_mode = 1'b0;
  logic        inexact_sup = 1'b0;
  logic [19:0] lane_flags = '0;
  logic [3:0]  lane_valid = 4'hF;
  logic [31:0] ctrl_in = '0;
  logic        busy, done, trap;
  logic [7:0]  exc_code;
  logic [3:0]  last_idx;
  logic [31:0] ctrl_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 4 ns period

  vfx_trap_encoder u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size),
    .single_mode(single_mode), .inexact_sup(inexact_sup),
    .lane_flags(lane_flags), .lane_valid(lane_valid), .ctrl_in(ctrl_in),
    .busy(busy), .done(done), .trap(trap), .exc_code(exc_code),
    .last_idx(last_idx), .ctrl_out(ctrl_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model: whole outcome at start, then countdown
  int          m_busy = 0, m_cnt = 0, m_done = 0, m_trap = 0;
  int          m_code = 0, m_last = 0;
  logic [31:0] m_ctrl = '0;
  int          p_trap, p_code, p_last;
  logic [31:0] p_ctrl;

  task automatic predict();
    int n;
    int acc;
    int en;
    p_trap = 0; p_code = 0; p_last = 0;
    acc = 0;
    en  = int'(ctrl_in[31:27]);
    n   = (elem_size == 2'd0) ? 4 : (elem_size == 2'd1) ? 2 : 1;
    if (single_mode) n = 1;
    for (int i = 0; i < n; i++) begin
      int f;
      int t;
      f = lane_valid[i] ? int'(lane_flags[i*5 +: 5]) : 0;
      acc = acc | f;
      t = f & en;
      if (inexact_sup) t = t & 'h1E;
      p_last = i;
      if (t != 0) begin
        p_trap = 1;
        p_code = i * 16 + ((t & 16) != 0 ? 1 : (t & 8) != 0 ? 2 :
                           (t & 4) != 0 ? 3 : (t & 2) != 0 ? 4 : 5);
        break;
      end
    end
    p_ctrl = p_trap ? ctrl_in : (ctrl_in | (32'(acc) << 19));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_trap = 0;
      m_code = 0; m_last = 0; m_ctrl = '0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1;
          m_trap = p_trap; m_code = p_code; m_last = p_last; m_ctrl = p_ctrl;
        end
      end else if (start) begin
        predict();
        m_busy = 1;
        m_cnt  = p_last + 1;
      end
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 busy",     32'(busy),     32'(m_busy));
      check("R2 done",     32'(done),     32'(m_done));
      check("R6 trap",     32'(trap),     32'(m_trap));
      check("R6 exc_code", 32'(exc_code), 32'(m_code));
      check("R7 last_idx", 32'(last_idx), 32'(m_last));
      check("R9 ctrl_out", ctrl_out,      m_ctrl);
    end
  end

  // ---------------- directed operations
  logic [7:0]  r_code;
  logic [31:0] r_ctrl;
  logic [3:0]  r_last;
  logic        r_trap;
  int          r_dones;

  task automatic run_op(input logic [1:0] sz, input logic sg, input logic sp,
                        input logic [19:0] fl, input logic [3:0] vl,
                        input logic [31:0] cr, input logic poke);
    @(negedge clk);
    elem_size = sz; single_mode = sg; inexact_sup = sp;
    lane_flags = fl; lane_valid = vl; ctrl_in = cr; start = 1'b1;
    r_dones = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (c == 0 && poke) begin
        start = 1'b1; lane_flags = 20'hFFFFF; ctrl_in = 32'hF800_0000;
        single_mode = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (done) begin
        r_dones++;
        r_code = exc_code; r_ctrl = ctrl_out; r_last = last_idx; r_trap = trap;
      end
    end
  endtask

  function automatic logic [19:0] lanes(input logic [4:0] f0, f1, f2, f3);
    return {f3, f2, f1, f0};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 code", 32'(exc_code), 0);
    check("R1 ctrl", ctrl_out, 0);
    check("R1 last", 32'(last_idx), 0);
    rst_n = 1'b1;

    // no enables, flags merge
    run_op(2'd0, 0, 0, lanes(5'h01, 0, 5'h04, 0), 4'hF, 32'h0, 0);
    check("R9 merge", r_ctrl, 32'h0028_0000);
    check("R2 four lanes", 32'(r_last), 3);
    check("R12 one done", 32'(r_dones), 1);

    // dz beats ovf in lane 1, walk stops there
    run_op(2'd0, 0, 0, lanes(0, 5'h0C, 5'h10, 0), 4'hF, 32'hF800_0000, 0);
    check("R4 dz priority", 32'(r_code), 32'h12);
    check("R7 stop lane", 32'(r_last), 1);
    check("R9 trap keeps ctrl", r_ctrl, 32'hF800_0000);

    // ovf beats unf
    run_op(2'd0, 0, 0, lanes(5'h06, 0, 0, 0), 4'hF, 32'hF800_0000, 0);
    check("R4 ovf priority", 32'(r_code), 32'h03);

    // inexact suppressed / not suppressed
    run_op(2'd0, 0, 1, lanes(1, 1, 1, 1), 4'hF, 32'h0800_1234, 0);
    check("R5 suppressed", 32'(r_trap), 0);
    check("R5 suppressed ctrl", r_ctrl, 32'h0808_1234);
    run_op(2'd0, 0, 0, lanes(1, 1, 1, 1), 4'hF, 32'h0800_1234, 0);
    check("R6 inexact code", 32'(r_code), 32'h05);
    check("R6 trap bit", 32'(r_trap), 1);

    // enable gating
    run_op(2'd0, 0, 0, lanes(5'h10, 0, 0, 0), 4'hF, 32'h4000_0000, 0);
    check("R3 not enabled", 32'(r_trap), 0);
    check("R3 sticky", r_ctrl, 32'h4080_0000);

    // single mode
    run_op(2'd0, 1, 0, lanes(0, 5'h10, 0, 0), 4'hF, 32'hF800_0000, 0);
    check("R8 single last", 32'(r_last), 0);
    check("R8 single no trap", 32'(r_code), 0);

    // two lanes ignore lanes 2,3
    run_op(2'd1, 0, 0, lanes(0, 0, 5'h10, 5'h10), 4'hF, 32'hF800_0000, 0);
    check("R2 two lanes", 32'(r_last), 1);
    check("R2 two lanes code", 32'(r_code), 0);

    // one lane
    run_op(2'd2, 0, 0, lanes(5'h11, 0, 0, 0), 4'hF, 32'hF800_0000, 0);
    check("R4 invalid first", 32'(r_code), 32'h01);
    run_op(2'd3, 0, 0, lanes(0, 5'h10, 0, 0), 4'hF, 32'hF800_0000, 0);
    check("R2 size3 one lane", 32'(r_last), 0);

    // invalid lane masked
    run_op(2'd0, 0, 0, lanes(5'h10, 5'h02, 0, 0), 4'hE, 32'hF800_0000, 0);
    check("R10 masked lane", 32'(r_code), 32'h14);

    // start while busy
    run_op(2'd0, 0, 0, lanes(5'h01, 0, 5'h04, 0), 4'hF, 32'h0, 1);
    check("R11 first op kept", r_ctrl, 32'h0028_0000);
    check("R11 no extra done", 32'(r_dones), 1);
    check("R12 hold", ctrl_out, 32'h0028_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule